// File: doc/BRIEF.md
# Single-Channel Byte Transfer Engine with Circular Reload

This block moves single bytes between one peripheral data port and a local synchronous memory. Software writes the element count, the memory base address, the direction and the mode, and then sets the enable bit. While the channel is enabled, each accepted byte goes to or comes from the memory location at base plus the current index. A live remaining-count register goes down by one per element, so a consumer can derive the current write position as length minus remaining.

In normal mode the channel stops after the last element and clears its own enable bit. In circular mode the index returns to the base, the count reloads and transfers continue without software action. This suits an endless receive buffer that is drained by software on half-way and complete events. Both events are sticky flags that software clears by writing ones. Each flag has its own interrupt enable.

The peripheral side uses two valid/ready streams. For receive (peripheral to memory), the peripheral holds `rx_valid` and `rx_data` until the channel raises `rx_ready`. With no valid byte the channel waits indefinitely. For transmit (memory to peripheral), the channel fetches a byte, raises `tx_valid` and holds it, with `tx_data` stable, until the peripheral raises `tx_ready`. A byte counts as moved on the cycle where valid and ready are both high. Disabling the channel withdraws a pending `tx_valid`.

Top module: `dma_chan`

## Requirements
- R1: After reset all registers read zero, `irq` is low, `rx_ready` is low and `tx_valid` is low. The register map is:
  - address 0: control. Bit 0 enable, bit 1 direction (1 = memory to peripheral), bit 2 circular, bit 3 half-way interrupt enable, bit 4 complete interrupt enable.
  - address 1: length.
  - address 2: memory base.
  - address 3: remaining count, read only.
  - address 4: status. Bit 0 half-way flag, bit 1 complete flag.
- R2: A control write that sets enable while the length register is 0 is rejected, and the enable bit stays 0.
- R3: While the channel is enabled, writes to length, base, direction and circular mode are ignored. Writes to the enable bit and to the interrupt-enable bits still take effect.
- R4: In receive direction, `rx_ready` is high exactly while the channel is enabled. Each `rx_valid`/`rx_ready` handshake writes `rx_data` to memory at base + (length − remaining) in that same cycle. With no `rx_valid`, nothing moves and the remaining count holds.
- R5: In transmit direction, the channel reads memory at base + (length − remaining) and shows that byte on `tx_data`. The first `tx_valid` of a run appears 3 clock edges after the enabling write. `tx_valid` and `tx_data` hold unchanged while `tx_ready` is low.
- R6: The remaining count decrements by one on each handshake and shows the new value right after that clock edge.
- R7: In normal mode, on the handshake of the last element the remaining count becomes 0 and the enable bit clears. After that, `rx_ready` and `tx_valid` stay low.
- R8: In circular mode, on the handshake of the last element the remaining count reloads to the length, the index returns to the base and transfers continue.
- R9: The half-way flag sets when floor(length/2) elements of a pass have moved; it never sets for length 1. The complete flag sets when all elements of a pass have moved. Both repeat on every circular pass and stay set until cleared.
- R10: Writing a 1 to a status bit clears that flag, and writing a 0 leaves it unchanged. `irq` is high while any flag is set whose interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data, combinational on `cfg_addr` |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Peripheral has a received byte |
| rx_data | input | DW | Received byte |
| rx_ready | output | 1 | Channel accepts the received byte |
| tx_valid | output | 1 | Channel presents a byte to send |
| tx_data | output | DW | Byte to send |
| tx_ready | input | 1 | Peripheral takes the byte |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read strobe |

## Verification
The memory write address and data of a receive handshake appear in the same cycle, so the bench samples them just before the active edge with `rx_valid` high. The remaining count, the flags, `irq` and the enable bit change on the handshake edge, and they are read one nanosecond after that edge. On the transmit side the first `tx_valid` is due on the third edge after the enabling write. The bench confirms it is still low after the second edge and high after the third, and then holds `tx_ready` low for several cycles to see the byte stay put. Every transmitted byte is compared against the bench's own memory model at the index the requirements predict.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_LEN    = 3'd1;
  localparam logic [2:0] REG_BASE   = 3'd2;
  localparam logic [2:0] REG_REMAIN = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;

  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_CIRC = 2;
  localparam int CB_HIE  = 3;
  localparam int CB_CIE  = 4;

  localparam int SB_HALF = 0;
  localparam int SB_DONE = 1;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_READ,
    XS_LATCH,
    XS_SEND
  } xfer_st_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic [CW-1:0] remain_i,
  input  logic          ev_ht_i,
  input  logic          ev_tc_i,
  input  logic          stop_i,
  output logic          en_o,
  output logic          dir_o,
  output logic          circ_o,
  output logic [CW-1:0] len_o,
  output logic [AW-1:0] base_o,
  output logic          start_o,
  output logic          irq_o
);
  logic          en_q, dir_q, circ_q, hie_q, cie_q, ht_q, tc_q;
  logic [CW-1:0] len_q;
  logic [AW-1:0] base_q;
  logic          wr_ctrl, wr_len, wr_base, wr_stat;
  logic          clr_ht, clr_tc;

  assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_len  = cfg_we && (cfg_addr == REG_LEN);
  assign wr_base = cfg_we && (cfg_addr == REG_BASE);
  assign wr_stat = cfg_we && (cfg_addr == REG_STATUS);
  assign clr_ht  = wr_stat && cfg_wdata[SB_HALF];
  assign clr_tc  = wr_stat && cfg_wdata[SB_DONE];

  assign start_o = wr_ctrl && !en_q && cfg_wdata[CB_EN] && (len_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      circ_q <= 1'b0;
      hie_q  <= 1'b0;
      cie_q  <= 1'b0;
      ht_q   <= 1'b0;
      tc_q   <= 1'b0;
      len_q  <= '0;
      base_q <= '0;
    end else begin
      if (wr_ctrl) begin
        hie_q <= cfg_wdata[CB_HIE];
        cie_q <= cfg_wdata[CB_CIE];
        if (!en_q) begin
          dir_q  <= cfg_wdata[CB_DIR];
          circ_q <= cfg_wdata[CB_CIRC];
        end
      end
      if (start_o) begin
        en_q <= 1'b1;
      end else if (stop_i) begin
        en_q <= 1'b0;
      end else if (wr_ctrl && en_q) begin
        en_q <= cfg_wdata[CB_EN];
      end
      if (wr_len && !en_q) begin
        len_q <= cfg_wdata[CW-1:0];
      end
      if (wr_base && !en_q) begin
        base_q <= cfg_wdata[AW-1:0];
      end
      ht_q <= ev_ht_i || (ht_q && !clr_ht);
      tc_q <= ev_tc_i || (tc_q && !clr_tc);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL: begin
        cfg_rdata[CB_EN]   = en_q;
        cfg_rdata[CB_DIR]  = dir_q;
        cfg_rdata[CB_CIRC] = circ_q;
        cfg_rdata[CB_HIE]  = hie_q;
        cfg_rdata[CB_CIE]  = cie_q;
      end
      REG_LEN:    cfg_rdata[CW-1:0] = len_q;
      REG_BASE:   cfg_rdata[AW-1:0] = base_q;
      REG_REMAIN: cfg_rdata[CW-1:0] = remain_i;
      REG_STATUS: begin
        cfg_rdata[SB_HALF] = ht_q;
        cfg_rdata[SB_DONE] = tc_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  assign en_o   = en_q;
  assign dir_o  = dir_q;
  assign circ_o = circ_q;
  assign len_o  = len_q;
  assign base_o = base_q;
  assign irq_o  = (ht_q && hie_q) || (tc_q && cie_q);

  AST_NO_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (len_q != '0)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (!en_q || ($stable(len_q) && $stable(base_q) && $stable(dir_q) && $stable(circ_q)))); // R3
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !en_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !clr_tc) |=> tc_q); // R9
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          dir_i,
  input  logic          circ_i,
  input  logic [CW-1:0] len_i,
  input  logic [AW-1:0] base_i,
  input  logic          start_i,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] remain_o,
  output logic          ev_ht_o,
  output logic          ev_tc_o,
  output logic          stop_o
);
  logic [CW-1:0] remain_q, rem_nx, idx, half;
  logic [DW-1:0] hold_q;
  xfer_st_t      st_q;
  logic          rx_go, tx_go, step, tx_mode;

  assign tx_mode  = en_i && dir_i;
  assign idx      = len_i - remain_q;
  assign half     = len_i >> 1;
  assign rem_nx   = remain_q - CW'(1);

  assign rx_ready = en_i && !dir_i;
  assign rx_go    = rx_valid && rx_ready;
  assign tx_valid = tx_mode && (st_q == XS_SEND);
  assign tx_data  = hold_q;
  assign tx_go    = tx_valid && tx_ready;
  assign step     = rx_go || tx_go;

  assign ev_tc_o  = step && (rem_nx == '0);
  assign ev_ht_o  = step && (half != '0) && (rem_nx == (len_i - half));
  assign stop_o   = ev_tc_o && !circ_i;

  assign mem_addr  = base_i + AW'(idx);
  assign mem_en    = rx_go || (tx_mode && (st_q == XS_READ));
  assign mem_we    = rx_go;
  assign mem_wdata = rx_data;
  assign remain_o  = remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      hold_q   <= '0;
      st_q     <= XS_IDLE;
    end else begin
      if (start_i) begin
        remain_q <= len_i;
      end else if (step) begin
        if (rem_nx == '0) begin
          remain_q <= circ_i ? len_i : '0;
        end else begin
          remain_q <= rem_nx;
        end
      end
      if (st_q == XS_LATCH) begin
        hold_q <= mem_rdata;
      end
      if (!tx_mode) begin
        st_q <= XS_IDLE;
      end else begin
        case (st_q)
          XS_IDLE:  st_q <= XS_READ;
          XS_READ:  st_q <= XS_LATCH;
          XS_LATCH: st_q <= XS_SEND;
          XS_SEND:  if (tx_ready) st_q <= stop_o ? XS_IDLE : XS_READ;
          default:  st_q <= XS_IDLE;
        endcase
      end
    end
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && en_i) |=> (!en_i || (tx_valid && $stable(tx_data)))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (remain_q != '0)); // R6
  AST_NORMAL_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tc_o && !circ_i) |=> (remain_q == '0)); // R7
  AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (remain_q == CW'(1)) && circ_i) |=> (remain_q == len_i)); // R8
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 8,
  localparam int RW = (CW > AW) ? CW : AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  output logic          irq,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          en, dir, circ, start, ev_ht, ev_tc, stop;
  logic [CW-1:0] len, remain;
  logic [AW-1:0] base;

  dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .remain_i  (remain),
    .ev_ht_i   (ev_ht),
    .ev_tc_i   (ev_tc),
    .stop_i    (stop),
    .en_o      (en),
    .dir_o     (dir),
    .circ_o    (circ),
    .len_o     (len),
    .base_o    (base),
    .start_o   (start),
    .irq_o     (irq)
  );

  dma_xfer #(.AW(AW), .CW(CW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .dir_i     (dir),
    .circ_i    (circ),
    .len_i     (len),
    .base_i    (base),
    .start_i   (start),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .remain_o  (remain),
    .ev_ht_o   (ev_ht),
    .ev_tc_o   (ev_tc),
    .stop_o    (stop)
  );
endmodule

// File: tb/test_dma_chan.sv
`timescale 1ns/1ps
module test_dma_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic       irq;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       mem_en, mem_we;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata;
  logic [7:0] mem [256];

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  dma_chan i_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) mem[a] <= 8'(a) ^ 8'h5A;
      mem_rdata <= 8'd0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] nb;
    logic       dir;
    logic       circ;
    logic [7:0] rem;
    logic       ht;
    logic       tc;
    logic       en;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd8, 8'd3, 1'b0, 1'b0, 8'd5, 1'b0, 1'b0, 1'b1},
    '{8'd8, 8'd4, 1'b0, 1'b0, 8'd4, 1'b1, 1'b0, 1'b1},
    '{8'd8, 8'd8, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0},
    '{8'd7, 8'd3, 1'b0, 1'b0, 8'd4, 1'b1, 1'b0, 1'b1},
    '{8'd6, 8'd8, 1'b0, 1'b1, 8'd4, 1'b1, 1'b1, 1'b1},
    '{8'd5, 8'd5, 1'b1, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0},
    '{8'd4, 8'd6, 1'b1, 1'b1, 8'd2, 1'b1, 1'b1, 1'b1},
    '{8'd1, 8'd1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  function automatic int rem_after(input int len, input int k, input bit circ);
    if (k % len != 0) return len - (k % len);
    return circ ? len : 0;
  endfunction

  task automatic push_rx(input int base, input int len, input int k, input bit circ, input logic [7:0] d);
    logic [7:0] r;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #1;
    chk(rx_ready == 1'b1, "R4 rx_ready while enabled", rx_ready, 1);
    chk(mem_en && mem_we && (mem_addr == 8'(base + (k % len))) && (mem_wdata == d),
        "R4 write address", mem_addr, base + (k % len));
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
    rd(3'd3, r);
    chk(r == 8'(rem_after(len, k + 1, circ)), "R6 remaining after handshake", r, rem_after(len, k + 1, circ));
  endtask

  task automatic pull_tx(input int base, input int len, input int k, input bit circ);
    logic [7:0] r;
    @(negedge clk);
    tx_ready = 1'b1;
    #1;
    while (!tx_valid) begin
      @(negedge clk);
      #1;
    end
    chk(tx_data == mem[8'(base + (k % len))], "R5 transmitted byte", tx_data, mem[8'(base + (k % len))]);
    @(posedge clk);
    #1;
    tx_ready = 1'b0;
    rd(3'd3, r);
    chk(r == 8'(rem_after(len, k + 1, circ)), "R6 remaining after handshake", r, rem_after(len, k + 1, circ));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      chk(r == 8'd0, "R1 register reads zero after reset", r, 0);
    end
    chk(!irq && !rx_ready && !tx_valid, "R1 outputs low after reset", {irq, rx_ready, tx_valid}, 0);

    // table of vectors
    for (int v = 0; v < 8; v++) begin
      int base;
      base = v * 24;
      wr(3'd0, 8'h00);
      wr(3'd4, 8'h03);
      wr(3'd1, VECS[v].len);
      wr(3'd2, 8'(base));
      wr(3'd0, {5'd0, VECS[v].circ, VECS[v].dir, 1'b1});
      for (int k = 0; k < int'(VECS[v].nb); k++) begin
        if (VECS[v].dir) pull_tx(base, int'(VECS[v].len), k, VECS[v].circ);
        else push_rx(base, int'(VECS[v].len), k, VECS[v].circ, 8'(v * 16 + k));
      end
      rd(3'd3, r);
      chk(r == VECS[v].rem, VECS[v].circ ? "R8 remaining after wrap" : "R7 remaining at end", r, VECS[v].rem);
      rd(3'd4, r);
      chk(r[0] == VECS[v].ht, "R9 half-way flag", r[0], VECS[v].ht);
      chk(r[1] == VECS[v].tc, "R9 complete flag", r[1], VECS[v].tc);
      rd(3'd0, r);
      chk(r[0] == VECS[v].en, VECS[v].circ ? "R8 still enabled" : "R7 enable after run", r[0], VECS[v].en);
      if (!VECS[v].en) chk(!rx_ready && !tx_valid, "R7 idle after stop", {rx_ready, tx_valid}, 0);
    end

    // R2 zero length rejected
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h03);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h01);
    rd(3'd0, r);
    chk(r[0] == 1'b0, "R2 enable rejected for length 0", r[0], 0);
    chk(rx_ready == 1'b0, "R2 no receive with length 0", rx_ready, 0);

    // R3 configuration frozen while enabled
    wr(3'd1, 8'd8);
    wr(3'd2, 8'h80);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd3);
    wr(3'd2, 8'h40);
    wr(3'd0, 8'h07);
    rd(3'd1, r);
    chk(r == 8'd8, "R3 length held", r, 8);
    rd(3'd2, r);
    chk(r == 8'h80, "R3 base held", r, 8'h80);
    rd(3'd0, r);
    chk(r == 8'h01, "R3 direction and mode held", r, 1);
    push_rx(8'h80, 8, 0, 1'b0, 8'hC3);
    // R4 waits with no request
    repeat (40) @(posedge clk);
    #1;
    rd(3'd3, r);
    chk(r == 8'd7, "R4 remaining holds without request", r, 7);

    // R10 clearing and interrupt
    for (int k = 1; k < 4; k++) push_rx(8'h80, 8, k, 1'b0, 8'(k));
    chk(irq == 1'b0, "R10 irq low with enables off", irq, 0);
    wr(3'd0, 8'h09);
    chk(irq == 1'b1, "R10 irq from half-way flag", irq, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, r);
    chk(r == 8'h00 && irq == 1'b0, "R10 half-way flag cleared", r, 0);
    for (int k = 4; k < 8; k++) push_rx(8'h80, 8, k, 1'b0, 8'(k));
    rd(3'd4, r);
    chk(r == 8'h02, "R9 only complete flag after pass", r, 2);
    chk(irq == 1'b0, "R10 complete flag masked", irq, 0);
    wr(3'd4, 8'h00);
    rd(3'd4, r);
    chk(r == 8'h02, "R10 writing zero keeps flag", r, 2);
    wr(3'd0, 8'h10);
    chk(irq == 1'b1, "R10 irq from complete flag", irq, 1);
    wr(3'd4, 8'h02);
    rd(3'd4, r);
    chk(r == 8'h00 && irq == 1'b0, "R10 complete flag cleared", r, 0);

    // R5 transmit latency and back-pressure
    wr(3'd1, 8'd3);
    wr(3'd2, 8'h20);
    wr(3'd0, 8'h03);
    @(posedge clk);
    @(posedge clk);
    #1;
    chk(tx_valid == 1'b0, "R5 no byte before third edge", tx_valid, 0);
    @(posedge clk);
    #1;
    chk(tx_valid == 1'b1, "R5 byte on third edge", tx_valid, 1);
    chk(rx_ready == 1'b0, "R4 receive closed in transmit direction", rx_ready, 0);
    d0 = tx_data;
    repeat (5) @(posedge clk);
    #1;
    chk(tx_valid == 1'b1 && tx_data == d0, "R5 byte held under back-pressure", tx_data, d0);
    for (int k = 0; k < 3; k++) pull_tx(8'h20, 3, k, 1'b0);
    rd(3'd0, r);
    chk(r[0] == 1'b0 && tx_valid == 1'b0, "R7 transmit run stopped", r[0], 0);

    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule